// File: doc/BRIEF.md
# Single-Cycle Main Control Decoder

This block turns the opcode and function fields of a fetched 32-bit instruction into every control the datapath of a single-cycle load/store core needs in that cycle. It is purely combinational. A separate path decodes the function field, and the result is used only when the opcode marks the register format. The block also chooses, for each instruction, whether the 16-bit immediate is sign-extended or zero-extended.

The datapath connects the outputs directly. They include the register write enable, the destination select, the ALU second-operand select, the memory write, the write-back source, two branch flavours, jump, jump-through-register, link, the extension mode and a 3-bit ALU operation. The core forms its PC source from `branch_o` and `branch_ne_o` together with the ALU zero flag. No state, clock or reset is involved, so the house state-machine layout reduces to one output process per decoding stage.

Encodings used throughout:
- Opcodes: register format 000000, load word 100011, store word 101011, branch-equal 000100, branch-not-equal 000101, add-immediate 001000, and-immediate 001100, or-immediate 001101, jump 000010, jump-and-link 000011.
- Function codes under the register format: add 100000, sub 100010, and 100100, or 100101, set-less-than 101010, jump-register 001000.
- `alu_op_o`: ADD=000, SUB=001, AND=010, OR=011, SLT=100.
- `dst_sel_o`: 00 = rt field, 01 = rd field, 10 = register 31.
- `ext_sign_o`: 1 = sign extension, 0 = zero extension.

Top module: `ctl_decoder_top`

## Requirements
- R1: For opcode 000000 with funct add, sub, and, or or slt, the outputs are `reg_wr_o`=1, `dst_sel_o`=01 and `alu_src_imm_o`=0. `alu_op_o` is ADD, SUB, AND, OR or SLT respectively. Every other control is 0.
- R2: For addi, andi and ori, the outputs are `reg_wr_o`=1, `dst_sel_o`=00 and `alu_src_imm_o`=1. `alu_op_o` is ADD, AND and OR respectively. No memory or flow control is asserted.
- R3: `ext_sign_o` is 0 for andi and ori. It is 1 for addi, load word, store word, branch-equal and branch-not-equal.
- R4: Load word gives `reg_wr_o`=1, `dst_sel_o`=00, `alu_src_imm_o`=1, `mem_to_reg_o`=1 and `alu_op_o`=ADD, with `mem_wr_o`=0.
- R5: Store word gives `mem_wr_o`=1, `reg_wr_o`=0, `alu_src_imm_o`=1 and `alu_op_o`=ADD.
- R6: Branch-equal asserts `branch_o` and branch-not-equal asserts `branch_ne_o`. Both set `alu_op_o`=SUB and `alu_src_imm_o`=0, with no register or memory write.
- R7: Jump asserts only `jump_o`. Jump-and-link asserts `jump_o`, `link_o` and `reg_wr_o`, with `dst_sel_o`=10.
- R8: Opcode 000000 with funct 001000 asserts only `jump_reg_o`. Every other output is 0.
- R9: Any opcode outside the list, and opcode 000000 with any funct outside the list, drives every output to 0.
- R10: At most one of `branch_o`, `branch_ne_o`, `jump_o` and `jump_reg_o` is high at a time. `mem_wr_o` and `reg_wr_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Opcode field of the instruction |
| fn_i | input | 6 | Function field of the instruction |
| reg_wr_o | output | 1 | Register file write enable |
| dst_sel_o | output | 2 | Destination register select (rt, rd, r31) |
| alu_src_imm_o | output | 1 | ALU second operand from extended immediate |
| mem_wr_o | output | 1 | Data memory write enable |
| mem_to_reg_o | output | 1 | Write-back from memory read data |
| branch_o | output | 1 | Branch if ALU result is zero |
| branch_ne_o | output | 1 | Branch if ALU result is non-zero |
| jump_o | output | 1 | Jump to the direct target |
| jump_reg_o | output | 1 | Jump to the address held in a register |
| link_o | output | 1 | Write return address as write-back value |
| ext_sign_o | output | 1 | Immediate extension: 1 signed, 0 unsigned |
| alu_op_o | output | 3 | ALU operation code |

## Verification
The checker assumes only that both input fields carry defined 0/1 values while its immediate checks run. It does not assume the inputs belong to the listed encodings, so the unknown-code properties stay live. The stimulus keeps within this by driving every one of the 4096 opcode/funct pairs from a defined starting value. Because of that, each legal instruction and each undefined code meets the properties and the bench's arithmetic reference model.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OP_W  = 6;
    localparam int FN_W  = 6;
    localparam int ALU_W = 3;
    localparam int DST_W = 2;

    localparam logic [OP_W-1:0] OP_RTYPE = 6'b000000;
    localparam logic [OP_W-1:0] OP_LW    = 6'b100011;
    localparam logic [OP_W-1:0] OP_SW    = 6'b101011;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'b000100;
    localparam logic [OP_W-1:0] OP_BNE   = 6'b000101;
    localparam logic [OP_W-1:0] OP_ADDI  = 6'b001000;
    localparam logic [OP_W-1:0] OP_ANDI  = 6'b001100;
    localparam logic [OP_W-1:0] OP_ORI   = 6'b001101;
    localparam logic [OP_W-1:0] OP_J     = 6'b000010;
    localparam logic [OP_W-1:0] OP_JAL   = 6'b000011;

    localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
    localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
    localparam logic [FN_W-1:0] FN_AND = 6'b100100;
    localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
    localparam logic [FN_W-1:0] FN_SLT = 6'b101010;
    localparam logic [FN_W-1:0] FN_JR  = 6'b001000;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD = 3'b000,
        ALU_SUB = 3'b001,
        ALU_AND = 3'b010,
        ALU_OR  = 3'b011,
        ALU_SLT = 3'b100
    } alu_op_e;

    typedef enum logic [DST_W-1:0] {
        DST_RT = 2'b00,
        DST_RD = 2'b01,
        DST_RA = 2'b10
    } dst_sel_e;

    typedef struct packed {
        logic     reg_wr;
        dst_sel_e dst;
        logic     alu_src_imm;
        logic     mem_wr;
        logic     mem_to_reg;
        logic     branch;
        logic     branch_ne;
        logic     jump;
        logic     jump_reg;
        logic     link;
        logic     ext_sign;
        alu_op_e  alu_op;
    } ctl_t;

endpackage

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
    import ctl_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output ctl_t            ctl_o,
    output logic            rtype_o
);

    always_comb begin
        ctl_o   = '0;
        rtype_o = 1'b0;
        unique case (op_i)
            OP_RTYPE: begin
                rtype_o = 1'b1;
            end
            OP_LW: begin
                ctl_o.reg_wr      = 1'b1;
                ctl_o.dst         = DST_RT;
                ctl_o.alu_src_imm = 1'b1;
                ctl_o.mem_to_reg  = 1'b1;
                ctl_o.ext_sign    = 1'b1;
                ctl_o.alu_op      = ALU_ADD;
            end
            OP_SW: begin
                ctl_o.mem_wr      = 1'b1;
                ctl_o.alu_src_imm = 1'b1;
                ctl_o.ext_sign    = 1'b1;
                ctl_o.alu_op      = ALU_ADD;
            end
            OP_BEQ: begin
                ctl_o.branch   = 1'b1;
                ctl_o.ext_sign = 1'b1;
                ctl_o.alu_op   = ALU_SUB;
            end
            OP_BNE: begin
                ctl_o.branch_ne = 1'b1;
                ctl_o.ext_sign  = 1'b1;
                ctl_o.alu_op    = ALU_SUB;
            end
            OP_ADDI: begin
                ctl_o.reg_wr      = 1'b1;
                ctl_o.alu_src_imm = 1'b1;
                ctl_o.ext_sign    = 1'b1;
                ctl_o.alu_op      = ALU_ADD;
            end
            OP_ANDI: begin
                ctl_o.reg_wr      = 1'b1;
                ctl_o.alu_src_imm = 1'b1;
                ctl_o.alu_op      = ALU_AND;
            end
            OP_ORI: begin
                ctl_o.reg_wr      = 1'b1;
                ctl_o.alu_src_imm = 1'b1;
                ctl_o.alu_op      = ALU_OR;
            end
            OP_J: begin
                ctl_o.jump = 1'b1;
            end
            OP_JAL: begin
                ctl_o.jump   = 1'b1;
                ctl_o.link   = 1'b1;
                ctl_o.reg_wr = 1'b1;
                ctl_o.dst    = DST_RA;
            end
            default: begin
                ctl_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/ctl_fn_dec.sv
module ctl_fn_dec
    import ctl_pkg::*;
(
    input  logic [FN_W-1:0] fn_i,
    output alu_op_e         alu_op_o,
    output logic            arith_ok_o,
    output logic            is_jr_o
);

    always_comb begin
        alu_op_o   = ALU_ADD;
        arith_ok_o = 1'b0;
        is_jr_o    = 1'b0;
        unique case (fn_i)
            FN_ADD: begin alu_op_o = ALU_ADD; arith_ok_o = 1'b1; end
            FN_SUB: begin alu_op_o = ALU_SUB; arith_ok_o = 1'b1; end
            FN_AND: begin alu_op_o = ALU_AND; arith_ok_o = 1'b1; end
            FN_OR:  begin alu_op_o = ALU_OR;  arith_ok_o = 1'b1; end
            FN_SLT: begin alu_op_o = ALU_SLT; arith_ok_o = 1'b1; end
            FN_JR:  begin is_jr_o = 1'b1; end
            default: begin
                alu_op_o   = ALU_ADD;
                arith_ok_o = 1'b0;
                is_jr_o    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ctl_decoder_top.sv
module ctl_decoder_top
    import ctl_pkg::*;
(
    input  logic [5:0] op_i,
    input  logic [5:0] fn_i,
    output logic       reg_wr_o,
    output logic [1:0] dst_sel_o,
    output logic       alu_src_imm_o,
    output logic       mem_wr_o,
    output logic       mem_to_reg_o,
    output logic       branch_o,
    output logic       branch_ne_o,
    output logic       jump_o,
    output logic       jump_reg_o,
    output logic       link_o,
    output logic       ext_sign_o,
    output logic [2:0] alu_op_o
);

    ctl_t    main_ctl;
    ctl_t    sel_ctl;
    logic    is_rtype;
    alu_op_e fn_alu;
    logic    fn_arith;
    logic    fn_jr;

    ctl_main_dec u_main (
        .op_i    (op_i),
        .ctl_o   (main_ctl),
        .rtype_o (is_rtype)
    );

    ctl_fn_dec u_fn (
        .fn_i       (fn_i),
        .alu_op_o   (fn_alu),
        .arith_ok_o (fn_arith),
        .is_jr_o    (fn_jr)
    );

    always_comb begin
        sel_ctl = main_ctl;
        if (is_rtype) begin
            sel_ctl = '0;
            if (fn_arith) begin
                sel_ctl.reg_wr = 1'b1;
                sel_ctl.dst    = DST_RD;
                sel_ctl.alu_op = fn_alu;
            end else if (fn_jr) begin
                sel_ctl.jump_reg = 1'b1;
            end
        end
    end

    assign reg_wr_o      = sel_ctl.reg_wr;
    assign dst_sel_o     = sel_ctl.dst;
    assign alu_src_imm_o = sel_ctl.alu_src_imm;
    assign mem_wr_o      = sel_ctl.mem_wr;
    assign mem_to_reg_o  = sel_ctl.mem_to_reg;
    assign branch_o      = sel_ctl.branch;
    assign branch_ne_o   = sel_ctl.branch_ne;
    assign jump_o        = sel_ctl.jump;
    assign jump_reg_o    = sel_ctl.jump_reg;
    assign link_o        = sel_ctl.link;
    assign ext_sign_o    = sel_ctl.ext_sign;
    assign alu_op_o      = sel_ctl.alu_op;

endmodule

// File: rtl/ctl_decoder_chk.sv
module ctl_decoder_chk (
    input logic [5:0] op_i,
    input logic [5:0] fn_i,
    input logic       reg_wr_o,
    input logic [1:0] dst_sel_o,
    input logic       alu_src_imm_o,
    input logic       mem_wr_o,
    input logic       mem_to_reg_o,
    input logic       branch_o,
    input logic       branch_ne_o,
    input logic       jump_o,
    input logic       jump_reg_o,
    input logic       link_o,
    input logic       ext_sign_o,
    input logic [2:0] alu_op_o
);

    logic op_known;
    logic any_out;

    always_comb begin
        op_known = (op_i == 6'b000000) || (op_i == 6'b100011) || (op_i == 6'b101011) ||
                   (op_i == 6'b000100) || (op_i == 6'b000101) || (op_i == 6'b001000) ||
                   (op_i == 6'b001100) || (op_i == 6'b001101) || (op_i == 6'b000010) ||
                   (op_i == 6'b000011);
        any_out  = reg_wr_o | (|dst_sel_o) | alu_src_imm_o | mem_wr_o | mem_to_reg_o |
                   branch_o | branch_ne_o | jump_o | jump_reg_o | link_o | ext_sign_o |
                   (|alu_op_o);

        AST_FLOW_EXCLUSIVE: assert ($onehot0({branch_o, branch_ne_o, jump_o, jump_reg_o})); // R10
        AST_NO_WR_CLASH: assert (!(mem_wr_o && reg_wr_o)); // R10
        AST_STORE_SHAPE: assert (!mem_wr_o || (alu_src_imm_o && alu_op_o == 3'b000)); // R5
        AST_LOAD_SHAPE: assert (!mem_to_reg_o ||
                                (reg_wr_o && alu_src_imm_o && alu_op_o == 3'b000 && dst_sel_o == 2'b00)); // R4
        AST_BRANCH_SUB: assert (!(branch_o || branch_ne_o) ||
                                (alu_op_o == 3'b001 && !reg_wr_o && !alu_src_imm_o)); // R6
        AST_LINK_RA: assert (!link_o || (jump_o && reg_wr_o && dst_sel_o == 2'b10)); // R7
        AST_LOGIC_ZEXT: assert (!((op_i == 6'b001100) || (op_i == 6'b001101)) || !ext_sign_o); // R3
        AST_RTYPE_REGS: assert (!(op_i == 6'b000000 && reg_wr_o) ||
                                (dst_sel_o == 2'b01 && !alu_src_imm_o)); // R1
        AST_JR_ALONE: assert (!jump_reg_o || (op_i == 6'b000000 && fn_i == 6'b001000 && !reg_wr_o)); // R8
        AST_UNKNOWN_IDLE: assert (op_known || !any_out); // R9
    end

endmodule

bind ctl_decoder_top ctl_decoder_chk u_chk (
    .op_i          (op_i),
    .fn_i          (fn_i),
    .reg_wr_o      (reg_wr_o),
    .dst_sel_o     (dst_sel_o),
    .alu_src_imm_o (alu_src_imm_o),
    .mem_wr_o      (mem_wr_o),
    .mem_to_reg_o  (mem_to_reg_o),
    .branch_o      (branch_o),
    .branch_ne_o   (branch_ne_o),
    .jump_o        (jump_o),
    .jump_reg_o    (jump_reg_o),
    .link_o        (link_o),
    .ext_sign_o    (ext_sign_o),
    .alu_op_o      (alu_op_o)
);

// File: tb/ctl_decoder_top_tb_top.sv
module ctl_decoder_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] op;
    logic [5:0] fn;
    logic       reg_wr, alu_src, mem_wr, mem_to_reg, br, br_ne, jmp, jmp_reg, lnk, ext_s;
    logic [1:0] dst;
    logic [2:0] aluop;
    int         total = 0;
    int         bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    ctl_decoder_top dut_i (
        .op_i          (op),
        .fn_i          (fn),
        .reg_wr_o      (reg_wr),
        .dst_sel_o     (dst),
        .alu_src_imm_o (alu_src),
        .mem_wr_o      (mem_wr),
        .mem_to_reg_o  (mem_to_reg),
        .branch_o      (br),
        .branch_ne_o   (br_ne),
        .jump_o        (jmp),
        .jump_reg_o    (jmp_reg),
        .link_o        (lnk),
        .ext_sign_o    (ext_s),
        .alu_op_o      (aluop)
    );

    // vector layout: {reg_wr, dst[1:0], alu_src, mem_wr, mem_to_reg,
    //                 br, br_ne, jmp, jmp_reg, lnk, ext_s, aluop[2:0]}
    function automatic logic [14:0] pack(input int w, input int d, input int s, input int mw,
                                         input int m2r, input int b, input int bn, input int j,
                                         input int jr, input int l, input int e, input int a);
        return 15'(w * 16384 + d * 4096 + s * 2048 + mw * 1024 + m2r * 512 + b * 256 +
                   bn * 128 + j * 64 + jr * 32 + l * 16 + e * 8 + a);
    endfunction

    function automatic logic [14:0] model(input int o, input int f, output string tag);
        tag = "R9";
        if (o == 0) begin
            if (f == 32) begin tag = "R1"; return pack(1,1,0,0,0,0,0,0,0,0,0,0); end
            if (f == 34) begin tag = "R1"; return pack(1,1,0,0,0,0,0,0,0,0,0,1); end
            if (f == 36) begin tag = "R1"; return pack(1,1,0,0,0,0,0,0,0,0,0,2); end
            if (f == 37) begin tag = "R1"; return pack(1,1,0,0,0,0,0,0,0,0,0,3); end
            if (f == 42) begin tag = "R1"; return pack(1,1,0,0,0,0,0,0,0,0,0,4); end
            if (f == 8)  begin tag = "R8"; return pack(0,0,0,0,0,0,0,0,1,0,0,0); end
            return '0;
        end
        if (o == 8)  begin tag = "R2_R3"; return pack(1,0,1,0,0,0,0,0,0,0,1,0); end
        if (o == 12) begin tag = "R2_R3"; return pack(1,0,1,0,0,0,0,0,0,0,0,2); end
        if (o == 13) begin tag = "R2_R3"; return pack(1,0,1,0,0,0,0,0,0,0,0,3); end
        if (o == 35) begin tag = "R4";    return pack(1,0,1,0,1,0,0,0,0,0,1,0); end
        if (o == 43) begin tag = "R5";    return pack(0,0,1,1,0,0,0,0,0,0,1,0); end
        if (o == 4)  begin tag = "R6";    return pack(0,0,0,0,0,1,0,0,0,0,1,1); end
        if (o == 5)  begin tag = "R6";    return pack(0,0,0,0,0,0,1,0,0,0,1,1); end
        if (o == 2)  begin tag = "R7";    return pack(0,0,0,0,0,0,0,1,0,0,0,0); end
        if (o == 3)  begin tag = "R7";    return pack(1,2,0,0,0,0,0,1,0,1,0,0); end
        return '0;
    endfunction

    task automatic check_now(input string tag, input logic [14:0] exp);
        logic [14:0] act;
        act = {reg_wr, dst, alu_src, mem_wr, mem_to_reg, br, br_ne, jmp, jmp_reg, lnk, ext_s, aluop};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s op=%b fn=%b act=%b exp=%b", tag, op, fn, act, exp);
        end
    endtask

    initial begin
        string tag;
        logic [14:0] exp;
        op = 6'b111111;
        fn = 6'b111111;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // initial undefined opcode: all outputs idle (R9)
        check_now("R9_reset", '0);
        for (int o = 0; o < 64; o++) begin
            for (int f = 0; f < 64; f++) begin
                @(negedge clk);
                op = 6'(o);
                fn = 6'(f);
                #2;
                exp = model(o, f, tag);
                check_now(tag, exp);
                // R10: flow controls exclusive, no simultaneous writes
                total++;
                if ($countones({br, br_ne, jmp, jmp_reg}) > 1 || (mem_wr && reg_wr)) begin
                    bad++;
                    $display("FAIL R10 op=%b fn=%b act=%b exp=exclusive", op, fn,
                             {br, br_ne, jmp, jmp_reg, mem_wr, reg_wr});
                end
            end
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=timeout exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule